// File: doc/BRIEF.md
# Parallel Port Mode Negotiation Sequencer

This block is the host-side controller that moves a parallel port from its power-up compatibility state into an extended transfer mode. A client raises a one-cycle request that carries an 8-bit extensibility code. The sequencer first checks that the code is one it may send. It then drives the code onto the data lines and runs the two-phase handshake on SelectIn*, AUTOFD* and STROBE*. While it does this, it watches the peripheral's status lines (PError, ACK*, FAULT*, Select) through a synchronizer.

Each negotiation ends with a single outcome:
- the peripheral does not speak the protocol at all (not compliant),
- it speaks the protocol but refuses the mode (rejected),
- it accepts the mode (granted).

When a mode is granted, the port stays in that mode until the client asks for termination. The exit uses the method that fits the mode: a pulse on INIT* for the address/data strobed mode (code 0x40), and a return of SelectIn* low for every other mode. Both waits for the peripheral have a clock-count timeout, so a dead or absent peripheral cannot hang the port.

Top module: `pport_negotiator`

## Requirements
- R1: After reset and whenever `busy_o` is low, the lines rest at compatibility levels. These are `data_o`=0x00, `select_in_n_o`=0, and `autofd_n_o`, `strobe_n_o` and `init_n_o` all 1. `result_o` is 0 after reset.
- R2: Only the codes 0x00, 0x01, 0x04, 0x05, 0x10, 0x14, 0x20, 0x34, 0x40 and 0x80 are accepted. A request in idle with any other code, including 0x02 and 0x08, pulses `err_o` for one cycle in the cycle after the request. No line changes and `busy_o` stays low.
- R3: An accepted request drives `data_o` to the code, `select_in_n_o` to 1, `autofd_n_o` to 0 and `strobe_n_o` to 1. These levels hold until the synchronized status shows PError=1, ACK*=0, FAULT*=1 and Select=1.
- R4: If that first-phase pattern is not seen within `timeout_i` cycles, the block does three things. It pulses `done_o` with `result_o`=1 (not compliant). It makes `busy_o` low. It returns the lines to R1 levels. The pulse comes `timeout_i` cycles after the request edge, with one cycle of slack.
- R5: After the first-phase pattern, `strobe_n_o` goes low for exactly `strobe_w_i` cycles (at least 1). Then `strobe_n_o` and `autofd_n_o` return high in the same cycle.
- R6: In the second phase, a rising edge of the synchronized ACK* samples the status. PError=0, FAULT*=0 and Select=1 give `result_o`=3 (granted) and `mode_active_o`=1. Any other combination gives `result_o`=2 (rejected) and returns the lines to idle.
- R7: If no ACK* rising edge arrives within `timeout_i` cycles of the second phase, `result_o`=2 and the lines return to idle.
- R8: `term_i` in the active mode exits that mode. For code 0x40, `init_n_o` goes low for exactly `strobe_w_i` cycles while `select_in_n_o` stays 1, and then the lines return to idle. For every other code, `select_in_n_o` goes low in the cycle after `term_i` and `init_n_o` never falls.
- R9: `req_i` is ignored while `busy_o` is high. No second negotiation follows the first one.
- R10: `done_o` is a one-cycle pulse. `result_o` holds its value until the next `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start a negotiation (sampled only when idle) |
| req_code_i | input | 8 | Extensibility code to send |
| term_i | input | 1 | Leave the granted mode |
| timeout_i | input | TMO_W | Maximum wait, in cycles, for each peripheral response |
| strobe_w_i | input | SW_W | STROBE* and INIT* pulse width, in cycles |
| perror_i | input | 1 | PError status line (asynchronous) |
| ack_n_i | input | 1 | ACK* status line (asynchronous) |
| fault_n_i | input | 1 | FAULT* status line (asynchronous) |
| select_i | input | 1 | Select status line (asynchronous) |
| data_o | output | 8 | Data lines |
| select_in_n_o | output | 1 | SelectIn* line |
| autofd_n_o | output | 1 | AUTOFD* line |
| strobe_n_o | output | 1 | STROBE* line |
| init_n_o | output | 1 | INIT* line |
| busy_o | output | 1 | Sequence in progress or mode active |
| mode_active_o | output | 1 | A negotiated mode is in force |
| done_o | output | 1 | One-cycle pulse when a negotiation ends |
| result_o | output | 2 | Last outcome: 1 not compliant, 2 rejected, 3 granted |
| err_o | output | 1 | One-cycle pulse when a request is refused |

## Verification
A wrong state register shows up within one cycle as line levels that no legal phase produces. Examples are STROBE* low while AUTOFD* is high, or SelectIn* high with `busy_o` low. A miscounted timer shows up as a strobe or INIT* pulse of the wrong length, or as a `done_o` that arrives outside its one-cycle window. A wrong classification shows up as an `err_o` pulse, or a missing one, in the cycle after the request. The sweep covers all 256 codes.

// File: rtl/pport_neg_pkg.sv
package pport_neg_pkg;

  localparam int CODE_W = 8;

  typedef enum logic [1:0] {
    RES_NONE          = 2'd0,
    RES_NONCOMPLIANT  = 2'd1,
    RES_REJECTED      = 2'd2,
    RES_GRANTED       = 2'd3
  } neg_result_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PHASE1,
    ST_STROBE,
    ST_PHASE2,
    ST_ACTIVE,
    ST_EXIT_INIT
  } neg_state_e;

  typedef struct packed {
    logic perror;
    logic ack_n;
    logic fault_n;
    logic select;
  } stat_t;

  typedef struct packed {
    logic [CODE_W-1:0] data;
    logic              selin_n;
    logic              autofd_n;
    logic              strobe_n;
    logic              init_n;
  } lines_t;

  localparam stat_t STAT_RST = '{perror: 1'b0, ack_n: 1'b1, fault_n: 1'b1, select: 1'b0};

  function automatic lines_t lines_for(neg_state_e st, logic [CODE_W-1:0] code);
    lines_t l;
    l = '{data: '0, selin_n: 1'b0, autofd_n: 1'b1, strobe_n: 1'b1, init_n: 1'b1};
    unique case (st)
      ST_PHASE1: begin
        l.data = code; l.selin_n = 1'b1; l.autofd_n = 1'b0;
      end
      ST_STROBE: begin
        l.data = code; l.selin_n = 1'b1; l.autofd_n = 1'b0; l.strobe_n = 1'b0;
      end
      ST_PHASE2: begin
        l.data = code; l.selin_n = 1'b1;
      end
      ST_ACTIVE: l.selin_n = 1'b1;
      ST_EXIT_INIT: begin
        l.selin_n = 1'b1; l.init_n = 1'b0;
      end
      default: ;
    endcase
    return l;
  endfunction

endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
  parameter int          W      = 4,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= RST_VAL;
    else         stage_q[0] <= d_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[i] <= RST_VAL;
      else         stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/pport_code_class.sv
module pport_code_class
  import pport_neg_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output logic              ok_o,
  output logic              exit_init_o
);

  always_comb begin
    ok_o        = 1'b0;
    exit_init_o = 1'b0;
    unique case (code_i)
      8'h00, 8'h01, 8'h04, 8'h05,
      8'h10, 8'h14, 8'h20, 8'h34,
      8'h80: ok_o = 1'b1;
      8'h40: begin
        ok_o        = 1'b1;
        exit_init_o = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/pport_neg_fsm.sv
module pport_neg_fsm
  import pport_neg_pkg::*;
#(
  parameter int TMO_W = 16,
  parameter int SW_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              code_ok_i,
  input  logic              code_init_exit_i,
  input  logic              term_i,
  input  logic [TMO_W-1:0]  timeout_i,
  input  logic [SW_W-1:0]   strobe_w_i,
  input  stat_t             stat_i,
  output lines_t            lines_o,
  output logic              busy_o,
  output logic              active_o,
  output logic              done_o,
  output neg_result_e       result_o,
  output logic              err_o
);

  localparam int CNT_W = (TMO_W > SW_W) ? TMO_W : SW_W;

  neg_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              epp_q, epp_d;
  logic              ack_q;
  logic              done_d, err_d;
  neg_result_e       res_q, res_d;
  lines_t            lines_q;

  logic [CNT_W:0] cnt_inc, tmo_ext, sw_ext;
  logic           tmo_hit, sw_hit, phase1_ok, ack_rise, grant;

  assign cnt_inc  = {1'b0, cnt_q} + 1'b1;
  assign tmo_ext  = {{(CNT_W+1-TMO_W){1'b0}}, timeout_i};
  assign sw_ext   = {{(CNT_W+1-SW_W){1'b0}}, strobe_w_i};
  assign tmo_hit  = cnt_inc >= tmo_ext;
  assign sw_hit   = cnt_inc >= sw_ext;

  assign phase1_ok = stat_i.perror & ~stat_i.ack_n & stat_i.fault_n & stat_i.select;
  assign ack_rise  = stat_i.ack_n & ~ack_q;
  assign grant     = ~stat_i.perror & ~stat_i.fault_n & stat_i.select;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    code_d  = code_q;
    epp_d   = epp_q;
    res_d   = res_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_i) begin
          if (code_ok_i) begin
            state_d = ST_PHASE1;
            code_d  = code_i;
            epp_d   = code_init_exit_i;
            cnt_d   = '0;
          end else begin
            err_d = 1'b1;
          end
        end
      end
      ST_PHASE1: begin
        if (phase1_ok) begin
          state_d = ST_STROBE;
          cnt_d   = '0;
        end else if (tmo_hit) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          res_d   = RES_NONCOMPLIANT;
        end else begin
          cnt_d = cnt_inc[CNT_W-1:0];
        end
      end
      ST_STROBE: begin
        if (sw_hit) begin
          state_d = ST_PHASE2;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_inc[CNT_W-1:0];
        end
      end
      ST_PHASE2: begin
        if (ack_rise) begin
          done_d  = 1'b1;
          res_d   = grant ? RES_GRANTED : RES_REJECTED;
          state_d = grant ? ST_ACTIVE : ST_IDLE;
        end else if (tmo_hit) begin
          done_d  = 1'b1;
          res_d   = RES_REJECTED;
          state_d = ST_IDLE;
        end else begin
          cnt_d = cnt_inc[CNT_W-1:0];
        end
      end
      ST_ACTIVE: begin
        if (term_i) begin
          state_d = epp_q ? ST_EXIT_INIT : ST_IDLE;
          cnt_d   = '0;
        end
      end
      ST_EXIT_INIT: begin
        if (sw_hit) state_d = ST_IDLE;
        else        cnt_d   = cnt_inc[CNT_W-1:0];
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      code_q  <= '0;
      epp_q   <= 1'b0;
      ack_q   <= 1'b1;
      res_q   <= RES_NONE;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
      lines_q <= lines_for(ST_IDLE, '0);
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      code_q  <= code_d;
      epp_q   <= epp_d;
      ack_q   <= stat_i.ack_n;
      res_q   <= res_d;
      done_o  <= done_d;
      err_o   <= err_d;
      lines_q <= lines_for(state_d, code_d);
    end
  end

  assign lines_o  = lines_q;
  assign busy_o   = state_q != ST_IDLE;
  assign active_o = state_q == ST_ACTIVE;
  assign result_o = res_q;

endmodule

// File: rtl/pport_negotiator.sv
module pport_negotiator
  import pport_neg_pkg::*;
#(
  parameter int TMO_W       = 16,
  parameter int SW_W        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [CODE_W-1:0] req_code_i,
  input  logic              term_i,
  input  logic [TMO_W-1:0]  timeout_i,
  input  logic [SW_W-1:0]   strobe_w_i,
  input  logic              perror_i,
  input  logic              ack_n_i,
  input  logic              fault_n_i,
  input  logic              select_i,
  output logic [CODE_W-1:0] data_o,
  output logic              select_in_n_o,
  output logic              autofd_n_o,
  output logic              strobe_n_o,
  output logic              init_n_o,
  output logic              busy_o,
  output logic              mode_active_o,
  output logic              done_o,
  output logic [1:0]        result_o,
  output logic              err_o
);

  localparam int STAT_W = $bits(stat_t);

  stat_t       stat_raw, stat_sync;
  lines_t      lines;
  logic        code_ok, code_init_exit;
  neg_result_e result;

  assign stat_raw = '{perror: perror_i, ack_n: ack_n_i, fault_n: fault_n_i, select: select_i};

  pport_sync #(
    .W       (STAT_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (STAT_RST)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (stat_raw),
    .q_o    (stat_sync)
  );

  pport_code_class u_class (
    .code_i      (req_code_i),
    .ok_o        (code_ok),
    .exit_init_o (code_init_exit)
  );

  pport_neg_fsm #(
    .TMO_W (TMO_W),
    .SW_W  (SW_W)
  ) u_fsm (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .req_i            (req_i),
    .code_i           (req_code_i),
    .code_ok_i        (code_ok),
    .code_init_exit_i (code_init_exit),
    .term_i           (term_i),
    .timeout_i        (timeout_i),
    .strobe_w_i       (strobe_w_i),
    .stat_i           (stat_sync),
    .lines_o          (lines),
    .busy_o           (busy_o),
    .active_o         (mode_active_o),
    .done_o           (done_o),
    .result_o         (result),
    .err_o            (err_o)
  );

  assign data_o        = lines.data;
  assign select_in_n_o = lines.selin_n;
  assign autofd_n_o    = lines.autofd_n;
  assign strobe_n_o    = lines.strobe_n;
  assign init_n_o      = lines.init_n;
  assign result_o      = result;

endmodule

// File: rtl/pport_negotiator_chk.sv
module pport_negotiator_chk #(
  parameter int TMO_W       = 16,
  parameter int SW_W        = 8,
  parameter int SYNC_STAGES = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic [7:0]       req_code_i,
  input logic             term_i,
  input logic [TMO_W-1:0] timeout_i,
  input logic [SW_W-1:0]  strobe_w_i,
  input logic             perror_i,
  input logic             ack_n_i,
  input logic             fault_n_i,
  input logic             select_i,
  input logic [7:0]       data_o,
  input logic             select_in_n_o,
  input logic             autofd_n_o,
  input logic             strobe_n_o,
  input logic             init_n_o,
  input logic             busy_o,
  input logic             mode_active_o,
  input logic             done_o,
  input logic [1:0]       result_o,
  input logic             err_o
);

  logic [SW_W:0] lo_cnt_q;
  logic          stb_prev_q;
  logic [SW_W:0] sw_min;

  assign sw_min = (strobe_w_i == '0) ? (SW_W+1)'(1) : {1'b0, strobe_w_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_cnt_q   <= '0;
      stb_prev_q <= 1'b1;
    end else begin
      stb_prev_q <= strobe_n_o;
      if (!strobe_n_o) lo_cnt_q <= lo_cnt_q + 1'b1;
      else             lo_cnt_q <= '0;
    end
  end

  // R1: idle implies compatibility levels
  p_idle_lines_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!select_in_n_o && autofd_n_o && strobe_n_o && init_n_o && data_o == 8'h00));

  // R2: refused request causes no activity
  p_err_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !busy_o);

  // R5: strobe only inside the first-phase line setting
  p_strobe_phase_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_n_o |-> (select_in_n_o && !autofd_n_o));

  // R5: strobe low run meets the programmed width
  p_strobe_width_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_n_o && !stb_prev_q) |-> lo_cnt_q >= sw_min);

  // R6: granted outcome leaves the mode active
  p_grant_active_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && result_o == 2'd3) |-> mode_active_o);

  // R8: INIT* falls only out of an active mode
  p_init_exit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(init_n_o) |-> $past(mode_active_o));

  // R10: done and err never together; done is a single pulse
  p_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, err_o}));
  p_done_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

endmodule

bind pport_negotiator pport_negotiator_chk #(
  .TMO_W (TMO_W), .SW_W (SW_W), .SYNC_STAGES (SYNC_STAGES)
) u_chk (.*);

// File: tb/pport_negotiator_tb.sv
module pport_negotiator_tb;

  localparam int TMO_W = 16;
  localparam int SW_W  = 8;
  localparam int TMO   = 40;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             req_i = 1'b0;
  logic [7:0]       req_code_i = '0;
  logic             term_i = 1'b0;
  logic [TMO_W-1:0] timeout_i = TMO_W'(TMO);
  logic [SW_W-1:0]  strobe_w_i = SW_W'(3);
  logic             perror_i = 1'b0, ack_n_i = 1'b1, fault_n_i = 1'b1, select_i = 1'b1;
  logic [7:0]       data_o;
  logic             select_in_n_o, autofd_n_o, strobe_n_o, init_n_o;
  logic             busy_o, mode_active_o, done_o, err_o;
  logic [1:0]       result_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // peripheral behaviour controls
  bit p_comply = 1, p_accept = 1, p_ack_en = 1;
  int p_st = 0;
  logic [7:0] seen_code = '0;
  int last_stb_w = 0, stb_run = 0;
  int last_init_w = 0, init_run = 0, init_falls = 0;

  always #2 clk_i = ~clk_i;

  pport_negotiator #(.TMO_W(TMO_W), .SW_W(SW_W), .SYNC_STAGES(2)) u_dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // peripheral model
  initial begin
    forever begin
      @(negedge clk_i);
      if (!rst_ni || select_in_n_o == 1'b0) begin
        perror_i = 0; ack_n_i = 1; fault_n_i = 1; select_i = 1; p_st = 0;
      end else if (p_st == 0 && !autofd_n_o) begin
        seen_code = data_o;
        if (p_comply) begin
          perror_i = 1; ack_n_i = 0; fault_n_i = 1; select_i = 1;
        end
        p_st = 1;
      end else if (p_st == 1 && !strobe_n_o) begin
        p_st = 2;
      end else if (p_st == 2 && autofd_n_o) begin
        if (p_ack_en) begin
          if (p_accept) begin perror_i = 0; fault_n_i = 0; select_i = 1; end
          else          begin perror_i = 0; fault_n_i = 1; select_i = 0; end
          ack_n_i = 1;
        end
        p_st = 3;
      end
    end
  end

  // pulse width monitor
  initial begin
    forever begin
      @(negedge clk_i);
      if (!strobe_n_o) stb_run++;
      else if (stb_run != 0) begin last_stb_w = stb_run; stb_run = 0; end
      if (!init_n_o) begin
        if (init_run == 0) init_falls++;
        init_run++;
      end else if (init_run != 0) begin last_init_w = init_run; init_run = 0; end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic bit code_ok(input logic [7:0] c);
    return c inside {8'h00, 8'h01, 8'h04, 8'h05, 8'h10, 8'h14, 8'h20, 8'h34, 8'h40, 8'h80};
  endfunction

  function automatic bit lines_idle();
    return data_o == 8'h00 && !select_in_n_o && autofd_n_o && strobe_n_o && init_n_o;
  endfunction

  // issue request; returns cycles to done/err and whether err
  task automatic request(input logic [7:0] c, output int n, output bit got_err);
    @(negedge clk_i);
    req_i = 1; req_code_i = c;
    @(negedge clk_i);
    req_i = 0;
    n = 1; got_err = 0;
    while (!done_o && !err_o && n < 2000) begin
      @(negedge clk_i);
      n++;
    end
    got_err = err_o;
  endtask

  task automatic terminate();
    @(negedge clk_i);
    term_i = 1;
    @(negedge clk_i);
    term_i = 0;
  endtask

  initial begin
    int n;
    bit ge;
    logic [1:0] held;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check(lines_idle() && !busy_o && result_o == 2'd0, "R1 reset levels", result_o, 0);
    rst_ni = 1;
    repeat (2) @(negedge clk_i);

    // R2/R3/R5/R6/R8 sweep over every code
    for (int c = 0; c < 256; c++) begin
      logic [7:0] cc = 8'(c);
      int falls0 = init_falls;
      if (!code_ok(cc)) begin
        @(negedge clk_i);
        req_i = 1; req_code_i = cc;
        @(negedge clk_i);
        req_i = 0;
        check(err_o && !busy_o && lines_idle(), "R2 refused code", int'(cc), 1);
        @(negedge clk_i);
        check(!err_o && !busy_o && lines_idle(), "R2 no activity after refusal", int'(busy_o), 0);
      end else begin
        request(cc, n, ge);
        check(!ge && done_o && result_o == 2'd3 && mode_active_o, "R6 granted", result_o, 3);
        check(seen_code == cc, "R3 code on data lines", seen_code, int'(cc));
        check(last_stb_w == 3, "R5 strobe width", last_stb_w, 3);
        terminate();
        if (cc == 8'h40) begin
          check(!init_n_o && select_in_n_o, "R8 init exit starts", init_n_o, 0);
          repeat (5) @(negedge clk_i);
          check(last_init_w == 3 && lines_idle() && !busy_o, "R8 init pulse width", last_init_w, 3);
        end else begin
          check(!select_in_n_o && lines_idle() && !busy_o, "R8 selectin exit", select_in_n_o, 0);
          check(init_falls == falls0, "R8 init untouched", init_falls - falls0, 0);
        end
      end
    end

    // R4 non-compliant timeout, and R9 request ignored while busy
    p_comply = 0;
    @(negedge clk_i);
    req_i = 1; req_code_i = 8'h40;
    @(negedge clk_i);
    req_i = 0;
    n = 1;
    repeat (5) @(negedge clk_i);
    n += 5;
    req_i = 1; req_code_i = 8'h10;
    @(negedge clk_i);
    req_i = 0; n++;
    while (!done_o && n < 2000) begin @(negedge clk_i); n++; end
    check(result_o == 2'd1 && !busy_o && lines_idle(), "R4 not compliant", result_o, 1);
    check(n >= TMO && n <= TMO + 1, "R4 timeout window", n, TMO);
    repeat (4) @(negedge clk_i);
    check(!busy_o && lines_idle(), "R9 busy request ignored", busy_o, 0);
    // R10 result held
    held = result_o;
    check(!done_o && result_o == held, "R10 result holds, done one cycle", done_o, 0);

    // R6 rejected
    p_comply = 1; p_accept = 0;
    request(8'h20, n, ge);
    check(result_o == 2'd2, "R6 rejected", result_o, 2);
    @(negedge clk_i);
    check(!busy_o && lines_idle() && !mode_active_o, "R6 idle after reject", busy_o, 0);

    // R7 second-phase timeout
    p_accept = 1; p_ack_en = 0;
    request(8'h01, n, ge);
    check(result_o == 2'd2, "R7 phase2 timeout", result_o, 2);
    @(negedge clk_i);
    check(!busy_o && lines_idle(), "R7 idle after timeout", busy_o, 0);
    p_ack_en = 1;

    // R5 other widths, including 0 treated as 1
    for (int w = 0; w < 6; w++) begin
      strobe_w_i = SW_W'(w);
      request(8'h40, n, ge);
      check(last_stb_w == ((w == 0) ? 1 : w), "R5 strobe width sweep", last_stb_w, (w == 0) ? 1 : w);
      terminate();
      repeat (8) @(negedge clk_i);
      check(last_init_w == ((w == 0) ? 1 : w), "R8 init width sweep", last_init_w, (w == 0) ? 1 : w);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule